// File: doc/BRIEF.md
# ADC Serial Command Front End

This block is the serial slave side of a multi-channel converter's command port. A host drives chip-select, a serial clock and a data line. The block oversamples all three with its own system clock and groups the bits into bytes. The first byte of each transaction is either a setup byte or a conversion command. A setup byte carries a two-bit clock-mode field. It can also name one of two eight-bit range registers, unipolar or bipolar, to take the byte that comes next. Any other first byte is handed to the downstream controller as a one-cycle conversion write.

In the other direction the controller presents a 12-bit result together with a flag that says whether this result is signed. Signed results are bipolar differential or temperature conversions. The block stores the result as a 16-bit frame, with a two's-complement MSB flip applied when the flag is set. It shifts the frame out MSB first during the next transaction. The host may idle the serial clock low or high, provided its phase setting matches its polarity setting.

Top module: `adc_cmd_front`

## Requirements
- R1: After reset the clock-mode output is 2'b10, both range registers are 8'h00, the conversion-write strobe is low and the serial output is 0.
- R2: While chip-select is low, the data line is sampled on each rising serial clock edge and assembled into bytes, most significant bit first.
- R3: A first byte whose bits 7:6 equal 2'b01 is a setup byte, and its bits 5:4 become the new clock-mode output.
- R4: In a setup byte, bits 1:0 choose where the next byte of the same transaction goes: 2'b10 sends it to the unipolar register, 2'b11 to the bipolar register, and 2'b00 or 2'b01 discard it.
- R5: A first byte without the setup prefix raises the conversion-write strobe for exactly one system clock, with that byte on the conversion-byte output.
- R6: Bytes after the second byte of a setup transaction, and bytes after a conversion byte, change no output.
- R7: Raising chip-select before a byte is complete discards the partial byte, and the next transaction decodes its first eight bits as a fresh first byte.
- R8: The serial output presents a 16-bit frame, MSB first: four zero bits and then the 12-bit result. It advances one bit per falling serial clock edge. The frame holds the result captured by the last load strobe before chip-select fell.
- R9: When the signed flag is set at load time, bit 11 of the result is inverted, which turns offset binary into two's complement. When the flag is clear, the 12 bits are sent unchanged.
- R10: With the clock idling high, the falling edge that comes before the first rising edge of a transaction does not advance the frame, so both idle levels receive the same bit sequence.
- R11: Each high-to-low chip-select transition starts a new transaction whose first byte is decoded afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used for oversampling |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial result data to the host |
| res_load | input | 1 | Strobe that captures a new result |
| res_data | input | 12 | Conversion result, offset binary |
| res_twos | input | 1 | Send this result in two's complement |
| clk_mode | output | 2 | Clock-mode field from the last setup byte |
| uni_cfg | output | 8 | Unipolar range register |
| bip_cfg | output | 8 | Bipolar range register |
| conv_wr | output | 1 | One-cycle strobe for a conversion command |
| conv_byte | output | 8 | Conversion command byte |

## Verification
Setup bytes are sent with each of the four selector codes. The unipolar, bipolar and discard cases are told apart by the register contents read back after each transaction. Conversion bytes are sent alone, followed by trailing bytes, and as a prefix to a byte that looks like a setup byte; this shows that only the first byte is decoded. Frames are read back with the clock idling low and high, using results at the extremes (0x800, 0x7FF, 0xFFF) with the signed flag both set and clear, so that a bit slip, a missed MSB flip or an early shift each gives a different word. A five-bit aborted transaction followed by a full setup shows whether the bit counter restarts.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
    localparam int BYTE_W    = 8;
    localparam int RES_W     = 12;
    localparam int FRAME_W   = 16;
    localparam int CNT_W     = $clog2(BYTE_W);
    localparam int PAD_W     = FRAME_W - RES_W;
    localparam logic [1:0] SETUP_TAG  = 2'b01;
    localparam logic [1:0] CKMODE_RST = 2'b10;

    typedef enum logic [1:0] {
        DST_NONE = 2'd0,
        DST_UNI  = 2'd1,
        DST_BIP  = 2'd2
    } dest_e;

    typedef struct packed {
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic              first;
        dest_e             dest;
        logic [1:0]        ckmode;
        logic [BYTE_W-1:0] uni;
        logic [BYTE_W-1:0] bip;
        logic              conv_wr;
        logic [BYTE_W-1:0] conv_byte;
    } rx_state_t;

    typedef struct packed {
        logic [FRAME_W-1:0] hold;
        logic [FRAME_W-1:0] sh;
        logic               armed;
    } tx_state_t;
endpackage

// File: rtl/adc_cmd_sync.sv
module adc_cmd_sync #(
    parameter int                 WIDTH   = 3,
    parameter int                 STAGES  = 2,
    parameter logic [WIDTH-1:0]   RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[b]}};
                prev_q  <= RST_VAL[b];
            end else begin
                chain_q <= {chain_q[STAGES-2:0], async_i[b]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign level_o[b] = chain_q[STAGES-1];
        assign rise_o[b]  = chain_q[STAGES-1] & ~prev_q;
        assign fall_o[b]  = ~chain_q[STAGES-1] & prev_q;
    end
endmodule

// File: rtl/adc_cmd_rx.sv
module adc_cmd_rx
    import adc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_low,
    input  logic              cs_fall,
    input  logic              sclk_rise,
    input  logic              mosi_s,
    output logic [1:0]        clk_mode,
    output logic [BYTE_W-1:0] uni_cfg,
    output logic [BYTE_W-1:0] bip_cfg,
    output logic              conv_wr,
    output logic [BYTE_W-1:0] conv_byte
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    rx_state_t         d, q;
    logic [BYTE_W-1:0] byte_w;

    always_comb begin
        d         = q;
        d.conv_wr = 1'b0;
        byte_w    = {q.sh[BYTE_W-2:0], mosi_s};
        if (cs_fall) begin
            d.cnt   = '0;
            d.first = 1'b1;
            d.dest  = DST_NONE;
        end else if (!cs_low) begin
            d.cnt = '0;
        end else if (sclk_rise) begin
            d.sh  = byte_w;
            d.cnt = q.cnt + 1'b1;
            if (q.cnt == LAST_BIT) begin
                if (q.first) begin
                    d.first = 1'b0;
                    if (byte_w[7:6] == SETUP_TAG) begin
                        d.ckmode = byte_w[5:4];
                        if (byte_w[1]) d.dest = byte_w[0] ? DST_BIP : DST_UNI;
                        else           d.dest = DST_NONE;
                    end else begin
                        d.conv_wr   = 1'b1;
                        d.conv_byte = byte_w;
                    end
                end else begin
                    case (q.dest)
                        DST_UNI: d.uni = byte_w;
                        DST_BIP: d.bip = byte_w;
                        default: ;
                    endcase
                    d.dest = DST_NONE;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q           <= '0;
            q.first     <= 1'b1;
            q.dest      <= DST_NONE;
            q.ckmode    <= CKMODE_RST;
        end else begin
            q <= d;
        end
    end

    assign clk_mode  = q.ckmode;
    assign uni_cfg   = q.uni;
    assign bip_cfg   = q.bip;
    assign conv_wr   = q.conv_wr;
    assign conv_byte = q.conv_byte;

    assert_conv_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        conv_wr |=> !conv_wr);
    assert_mode_needs_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> $stable(clk_mode));
    assert_one_reg_per_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_rise |=> ($stable(uni_cfg) && $stable(bip_cfg)));
    assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_low && !sclk_rise) |=> (q.cnt == '0));
endmodule

// File: rtl/adc_cmd_tx.sv
module adc_cmd_tx
    import adc_cmd_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_low,
    input  logic             cs_fall,
    input  logic             sclk_rise,
    input  logic             sclk_fall,
    input  logic             res_load,
    input  logic [RES_W-1:0] res_data,
    input  logic             res_twos,
    output logic             miso
);
    tx_state_t          d, q;
    logic [RES_W-1:0]   fmt_w;

    always_comb begin
        d     = q;
        fmt_w = res_data;
        if (res_twos) fmt_w[RES_W-1] = ~res_data[RES_W-1];
        if (res_load) d.hold = {{PAD_W{1'b0}}, fmt_w};
        if (cs_fall) begin
            d.sh    = q.hold;
            d.armed = 1'b0;
        end else if (cs_low) begin
            if (sclk_rise) d.armed = 1'b1;
            if (sclk_fall && q.armed) d.sh = {q.sh[FRAME_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign miso = q.sh[FRAME_W-1];

    assert_shift_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(sclk_fall || cs_fall) |=> $stable(q.sh));
    assert_hold_until_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_low && !q.armed && !cs_fall) |=> $stable(q.sh));
endmodule

// File: rtl/adc_cmd_front.sv
module adc_cmd_front
    import adc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              miso,
    input  logic              res_load,
    input  logic [RES_W-1:0]  res_data,
    input  logic              res_twos,
    output logic [1:0]        clk_mode,
    output logic [BYTE_W-1:0] uni_cfg,
    output logic [BYTE_W-1:0] bip_cfg,
    output logic              conv_wr,
    output logic [BYTE_W-1:0] conv_byte
);
    localparam int IDX_MOSI = 0;
    localparam int IDX_SCLK = 1;
    localparam int IDX_CS   = 2;

    logic [2:0] lvl, rise, fall;

    adc_cmd_sync #(.WIDTH(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_n, sclk, mosi}),
        .level_o (lvl),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    adc_cmd_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (~lvl[IDX_CS]),
        .cs_fall   (fall[IDX_CS]),
        .sclk_rise (rise[IDX_SCLK]),
        .mosi_s    (lvl[IDX_MOSI]),
        .clk_mode  (clk_mode),
        .uni_cfg   (uni_cfg),
        .bip_cfg   (bip_cfg),
        .conv_wr   (conv_wr),
        .conv_byte (conv_byte)
    );

    adc_cmd_tx u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_low    (~lvl[IDX_CS]),
        .cs_fall   (fall[IDX_CS]),
        .sclk_rise (rise[IDX_SCLK]),
        .sclk_fall (fall[IDX_SCLK]),
        .res_load  (res_load),
        .res_data  (res_data),
        .res_twos  (res_twos),
        .miso      (miso)
    );
endmodule

// File: tb/adc_cmd_front_bench.sv
module adc_cmd_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
    logic        res_load = 1'b0, res_twos = 1'b0;
    logic [11:0] res_data = '0;
    logic        miso, conv_wr;
    logic [1:0]  clk_mode;
    logic [7:0]  uni_cfg, bip_cfg, conv_byte;
    logic [31:0] got;
    int checks = 0, fails = 0;
    logic [7:0] conv_q[$];

    always #5 clk = ~clk;

    adc_cmd_front u_adc_cmd_front (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .miso(miso), .res_load(res_load), .res_data(res_data),
        .res_twos(res_twos), .clk_mode(clk_mode), .uni_cfg(uni_cfg),
        .bip_cfg(bip_cfg), .conv_wr(conv_wr), .conv_byte(conv_byte)
    );

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load(input logic [11:0] v, input logic tw);
        res_data = v; res_twos = tw; res_load = 1'b1;
        wt(1);
        res_load = 1'b0;
        wt(1);
    endtask

    task automatic xfer(input bit idle, input int nb, input logic [31:0] data,
                        output logic [31:0] rx);
        rx = '0;
        sclk = idle;
        wt(4);
        cs_n = 1'b0;
        wt(8);
        for (int i = nb - 1; i >= 0; i--) begin
            if (idle) sclk = 1'b0;
            mosi = data[i];
            wt(8);
            rx = {rx[30:0], miso};
            sclk = 1'b1;
            wt(8);
            if (!idle) sclk = 1'b0;
        end
        wt(8);
        cs_n = 1'b1;
        wt(16);
    endtask

    // Scoreboard monitor for conversion strobes (R5)
    always @(negedge clk) begin
        if (rst_n && conv_wr) begin
            checks++;
            if (conv_q.size() == 0) begin
                fails++;
                $display("FAIL R5 unexpected strobe actual=%0h expected=none", conv_byte);
            end else begin
                logic [7:0] e;
                e = conv_q.pop_front();
                if (conv_byte !== e) begin
                    fails++;
                    $display("FAIL R5 conv byte actual=%0h expected=%0h", conv_byte, e);
                end
            end
        end
    end

    initial begin
        #2000000;
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        wt(3);
        rst_n = 1'b1;
        wt(2);
        chk("R1 clk_mode", clk_mode, 2'b10);
        chk("R1 uni", uni_cfg, 0);
        chk("R1 bip", bip_cfg, 0);
        chk("R1 conv_wr", conv_wr, 0);
        chk("R1 miso", miso, 0);

        // R2 R3 R4 R8: idle-low, setup to unipolar, unsigned frame
        load(12'hABC, 1'b0);
        xfer(1'b0, 16, {16'h0, 8'h42, 8'h5A}, got);
        chk("R8 frame idle-low", got[15:0], 16'h0ABC);
        chk("R3 clk_mode", clk_mode, 2'b00);
        chk("R2 R4 uni write", uni_cfg, 8'h5A);
        chk("R4 bip untouched", bip_cfg, 8'h00);

        // R9 R10: idle-high, setup to bipolar, signed frame
        load(12'h123, 1'b1);
        xfer(1'b1, 16, {16'h0, 8'h73, 8'hC3}, got);
        chk("R9 R10 frame idle-high signed", got[15:0], 16'h0923);
        chk("R3 clk_mode", clk_mode, 2'b11);
        chk("R4 bip write", bip_cfg, 8'hC3);
        chk("R4 uni kept", uni_cfg, 8'h5A);

        // R5 R6: conversion byte with a trailing byte
        load(12'hFFF, 1'b0);
        conv_q.push_back(8'h9D);
        xfer(1'b0, 16, {16'h0, 8'h9D, 8'h00}, got);
        chk("R8 frame full-scale", got[15:0], 16'h0FFF);
        chk("R6 clk_mode kept", clk_mode, 2'b11);
        chk("R6 uni kept", uni_cfg, 8'h5A);

        // R6 R11: conversion byte followed by setup-looking bytes
        load(12'h7FF, 1'b1);
        conv_q.push_back(8'h85);
        xfer(1'b1, 24, {8'h0, 8'h85, 8'h42, 8'h11}, got);
        chk("R9 frame 7FF signed", got[23:8], 16'h0FFF);
        chk("R6 clk_mode after conv", clk_mode, 2'b11);
        chk("R6 uni after conv", uni_cfg, 8'h5A);

        // R4: selector 00 discards next byte
        xfer(1'b0, 16, {16'h0, 8'h60, 8'hFF}, got);
        chk("R3 clk_mode sel00", clk_mode, 2'b10);
        chk("R4 sel00 uni", uni_cfg, 8'h5A);
        chk("R4 sel00 bip", bip_cfg, 8'hC3);

        // R4: selector 01 discards next byte
        xfer(1'b0, 16, {16'h0, 8'h41, 8'h77}, got);
        chk("R4 sel01 uni", uni_cfg, 8'h5A);
        chk("R4 sel01 bip", bip_cfg, 8'hC3);

        // R7: aborted partial byte then fresh setup
        xfer(1'b0, 5, 32'h1F, got);
        xfer(1'b0, 16, {16'h0, 8'h52, 8'h3C}, got);
        chk("R7 clk_mode after abort", clk_mode, 2'b01);
        chk("R7 uni after abort", uni_cfg, 8'h3C);

        // R9 R11: minimum signed value, new setup decoded again
        load(12'h800, 1'b1);
        xfer(1'b1, 16, {16'h0, 8'h62, 8'h00}, got);
        chk("R9 frame 800 signed", got[15:0], 16'h0000);
        chk("R11 uni rewritten", uni_cfg, 8'h00);
        chk("R11 clk_mode", clk_mode, 2'b10);

        wt(4);
        chk("R5 all strobes seen", conv_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule